// File: doc/BRIEF.md
# Multiplexed Row Refresh Scanner with PWM On-Time

This block is the refresh engine of a 20-column by 8-row LED dot-matrix driver. It walks a 160-bit dot latch one row at a time and turns each row on for a part of its time slot. It also drives the column enables for the lit row from the matching latch bits. A display-clock enable advances the scan. That enable comes from either an internal tick input or an external oscillator pin. The external pin is synchronised and edge-detected, and it can be divided by eight.

Each full refresh lasts 512 display ticks, made of eight row slots of 64 ticks each. The first four ticks of every slot are always dark. After them the row stays lit for the number of ticks that a 4-bit brightness code selects from a fixed nonlinear table. Row 0 has no LEDs and is never driven, although its slot is still counted. The blank input, the sleep bit and the brightness fields come in on two 7-bit control-word inputs. The 2-bit peak-current code goes unchanged to the analog column current sources, which sit outside this block.

Top module: `rowScanPwm`

## Requirements
- R1: Rows are scanned in the order 0, 1, … 7 and then back to 0. Each row slot lasts 64 display ticks, so one refresh lasts 512 ticks.
- R2: In the slot positions 0 to 3 (the first four ticks of every slot) no row enable and no column enable is asserted.
- R3: The brightness code is ctrlWord0 bits 3..0. Codes 0 to 15 map to 0, 1, 2, 3, 4, 5, 7, 9, 11, 14, 18, 22, 28, 36, 48 and 60 lit ticks. A row is lit only at slot positions from 4 up to 4 plus the table value, not including that last position.
- R4: While row r is lit, rowEn has only bit r set. colEn bit c then equals dotLatch bit 8c+r.
- R5: Row 0 is never driven. rowEn bit 0 is always 0, and all outputs stay off during the row-0 slot.
- R6: blank = 1 forces rowEn and colEn to zero in the same cycle. The scan counters keep advancing while blank is high.
- R7: ctrlWord0 bit 6 = 0 selects sleep. In sleep all outputs are off and the scan position is frozen. When the bit returns to 1, scanning resumes from the same position.
- R8: With useInternal = 0, each synchronised rising edge of extOsc is one display tick. With ctrlWord1 bit 1 = 1, only every eighth such edge is a tick.
- R9: With useInternal = 1, each cycle with intTick = 1 is one display tick. ctrlWord1 bit 1 then has no effect, and extOsc is ignored.
- R10: peakCode equals ctrlWord0 bits 5..4 at all times. The codes are 00 = 73 % (the reset default), 01 = 50 %, 10 = 31 % and 11 = 100 % of full-scale current.
- R11: After reset the scan is at row 0, slot position 0, with all row and column enables off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset of the scan state |
| intTick | input | 1 | Internal display-clock enable, one pulse per tick |
| extOsc | input | 1 | External display oscillator, asynchronous |
| useInternal | input | 1 | 1 = tick from intTick, 0 = tick from extOsc |
| blank | input | 1 | Forces all outputs off immediately |
| ctrlWord0 | input | 7 | Bit 6 awake, bits 5..4 peak current, bits 3..0 on-time code |
| ctrlWord1 | input | 7 | Bit 1 selects external divide-by-8; other bits unused here |
| dotLatch | input | 160 | Pixel latch, column c in bits 8c+7..8c, bit index = row |
| rowEn | output | 8 | One-hot row sink enable |
| colEn | output | 20 | Column source enables for the lit row |
| peakCode | output | 2 | Peak-current code for the column current sources |

## Verification
A slot or row counter that gets out of step shows at once on the ports. The lit window then falls at the wrong cycles of the slot, the wrong rowEn bit turns on, or colEn takes the pixel bits of another row. A cycle-by-cycle comparison against a bench model of the scan position catches this within one tick. A tick-source or prescaler fault changes how long a lit row stays on. Measuring one full lit run on the external path therefore exposes it within a single row slot of ticks. Sleep or blank logic that stops the counters when it should not, or lets them run when it should not, leaves the scan position shifted. The first lit row after the stimulus then appears at the wrong time.

// File: rtl/scanPkg.sv
package scanPkg;

  localparam int ROW_W = 3;

  // strobes from the scan control to the output datapath
  typedef struct packed {
    logic             lit;
    logic [ROW_W-1:0] row;
  } scanStrobe_t;

  // nonlinear on-time table: lit ticks per row slot for a 4-bit code
  function automatic logic [6:0] onTicks(input logic [3:0] code);
    logic [6:0] v;
    case (code)
      4'd0:  v = 7'd0;
      4'd1:  v = 7'd1;
      4'd2:  v = 7'd2;
      4'd3:  v = 7'd3;
      4'd4:  v = 7'd4;
      4'd5:  v = 7'd5;
      4'd6:  v = 7'd7;
      4'd7:  v = 7'd9;
      4'd8:  v = 7'd11;
      4'd9:  v = 7'd14;
      4'd10: v = 7'd18;
      4'd11: v = 7'd22;
      4'd12: v = 7'd28;
      4'd13: v = 7'd36;
      4'd14: v = 7'd48;
      default: v = 7'd60;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/scanCtrl.sv
module scanCtrl
  import scanPkg::*;
#(
  parameter int ROWS     = 8,
  parameter int SLOT_LEN = 64,
  parameter int GAP_LEN  = 4,
  parameter int PRE_DIV  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        intTick,
  input  logic        extOsc,
  input  logic        useInternal,
  input  logic        awake,
  input  logic        prescale,
  input  logic [3:0]  pwmCode,
  output scanStrobe_t strobe
);

  localparam int SLOT_W = $clog2(SLOT_LEN);
  localparam int PRE_W  = $clog2(PRE_DIV);

  logic [2:0]        extSync;
  logic              extEdge;
  logic [PRE_W-1:0]  preCnt;
  logic              extTick;
  logic              dispTick;
  logic [SLOT_W-1:0] slotCnt;
  logic [ROW_W-1:0]  rowCnt;
  logic              slotEnd;

  // two-flop synchroniser plus one flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[1:0], extOsc};
  end

  assign extEdge = extSync[1] & ~extSync[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (awake && extEdge) begin
      if (preCnt == PRE_W'(PRE_DIV - 1)) preCnt <= '0;
      else                               preCnt <= preCnt + 1'b1;
    end
  end

  assign extTick  = extEdge && (!prescale || preCnt == PRE_W'(PRE_DIV - 1));
  assign dispTick = awake && (useInternal ? intTick : extTick);
  assign slotEnd  = (slotCnt == SLOT_W'(SLOT_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
      rowCnt  <= '0;
    end else if (dispTick) begin
      slotCnt <= slotEnd ? '0 : slotCnt + 1'b1;
      if (slotEnd) begin
        if (rowCnt == ROW_W'(ROWS - 1)) rowCnt <= '0;
        else                            rowCnt <= rowCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.row = rowCnt;
    strobe.lit = awake && (rowCnt != '0)
                 && (int'(slotCnt) >= GAP_LEN)
                 && (int'(slotCnt) < GAP_LEN + int'(onTicks(pwmCode)));
  end

  a_r1_row_step: assert property (@(posedge clk) disable iff (!rstN)
    (dispTick && slotEnd) |=>
      (rowCnt == (($past(rowCnt) == ROW_W'(ROWS - 1)) ? '0 : $past(rowCnt) + 1'b1)));

  a_r7_sleep_hold: assert property (@(posedge clk) disable iff (!rstN)
    !awake |=> ($stable(slotCnt) && $stable(rowCnt)));

  a_r8_prescale_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!useInternal && prescale && extEdge && preCnt != PRE_W'(PRE_DIV - 1)) |=> $stable(slotCnt));

  a_r3_no_lit_when_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pwmCode == 4'd0) |-> !strobe.lit);

endmodule

// File: rtl/scanData.sv
module scanData
  import scanPkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  scanStrobe_t        strobe,
  input  logic [ROWS*COLS-1:0] dotLatch,
  input  logic               blank,
  output logic [ROWS-1:0]    rowEn,
  output logic [COLS-1:0]    colEn
);

  logic drive;
  assign drive = strobe.lit && !blank;

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    assign rowEn[r] = drive && (strobe.row == ROW_W'(r));
  end

  for (genvar c = 0; c < COLS; c++) begin : gCol
    logic [ROWS-1:0] colBits;
    assign colBits  = dotLatch[c*ROWS +: ROWS];
    assign colEn[c] = drive && colBits[strobe.row];
  end

  a_r4_one_row: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowEn));

  a_r4_cols_need_row: assert property (@(posedge clk) disable iff (!rstN)
    (colEn != '0) |-> (rowEn != '0));

  a_r5_row0_dark: assert property (@(posedge clk) disable iff (!rstN)
    rowEn[0] == 1'b0);

  a_r6_blank_dark: assert property (@(posedge clk) disable iff (!rstN)
    blank |-> (rowEn == '0 && colEn == '0));

endmodule

// File: rtl/rowScanPwm.sv
module rowScanPwm
  import scanPkg::*;
#(
  parameter int ROWS     = 8,
  parameter int COLS     = 20,
  parameter int SLOT_LEN = 64,
  parameter int GAP_LEN  = 4,
  parameter int PRE_DIV  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 intTick,
  input  logic                 extOsc,
  input  logic                 useInternal,
  input  logic                 blank,
  input  logic [6:0]           ctrlWord0,
  input  logic [6:0]           ctrlWord1,
  input  logic [ROWS*COLS-1:0] dotLatch,
  output logic [ROWS-1:0]      rowEn,
  output logic [COLS-1:0]      colEn,
  output logic [1:0]           peakCode
);

  scanStrobe_t strobe;
  logic unusedCtrlBits;

  assign unusedCtrlBits = ^{ctrlWord1[6:2], ctrlWord1[0]};
  assign peakCode       = ctrlWord0[5:4];

  scanCtrl #(
    .ROWS(ROWS), .SLOT_LEN(SLOT_LEN), .GAP_LEN(GAP_LEN), .PRE_DIV(PRE_DIV)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .intTick(intTick), .extOsc(extOsc),
    .useInternal(useInternal), .awake(ctrlWord0[6]), .prescale(ctrlWord1[1]),
    .pwmCode(ctrlWord0[3:0]), .strobe(strobe)
  );

  scanData #(.ROWS(ROWS), .COLS(COLS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dotLatch(dotLatch),
    .blank(blank), .rowEn(rowEn), .colEn(colEn)
  );

endmodule

// File: tb/tb_rowScanPwm.sv
module tb_rowScanPwm;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         intTick = 1'b0;
  logic         extOsc = 1'b0;
  logic         useInternal = 1'b1;
  logic         blank = 1'b0;
  logic [6:0]   ctrlWord0 = 7'b1001111;
  logic [6:0]   ctrlWord1 = 7'b0;
  logic [159:0] dotLatch = {5{32'hA5C3_96F0}};
  logic [7:0]   rowEn;
  logic [19:0]  colEn;
  logic [1:0]   peakCode;

  int checks = 0;
  int errors = 0;
  int mSlot = 0;
  int mRow = 0;
  bit extRun = 1'b0;
  int extHalf = 4;

  always #10 clk = ~clk;

  rowScanPwm dut (
    .clk(clk), .rstN(rstN), .intTick(intTick), .extOsc(extOsc),
    .useInternal(useInternal), .blank(blank), .ctrlWord0(ctrlWord0),
    .ctrlWord1(ctrlWord1), .dotLatch(dotLatch), .rowEn(rowEn),
    .colEn(colEn), .peakCode(peakCode)
  );

  function automatic int tbTable(input logic [3:0] code);
    int t [16] = '{0, 1, 2, 3, 4, 5, 7, 9, 11, 14, 18, 22, 28, 36, 48, 60};
    return t[code];
  endfunction

  // scan position model for the internal-tick path
  always @(posedge clk) begin
    if (!rstN) begin
      mSlot <= 0;
      mRow  <= 0;
    end else if (ctrlWord0[6] && useInternal && intTick) begin
      if (mSlot == 63) begin
        mSlot <= 0;
        mRow  <= (mRow == 7) ? 0 : mRow + 1;
      end else begin
        mSlot <= mSlot + 1;
      end
    end
  end

  // external oscillator generator
  initial begin
    forever begin
      repeat (extHalf) @(negedge clk);
      if (extRun) extOsc = ~extOsc;
    end
  end

  function automatic bit expLit();
    return ctrlWord0[6] && !blank && mRow != 0 && mSlot >= 4
           && mSlot < 4 + tbTable(ctrlWord0[3:0]);
  endfunction

  task automatic compareFor(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [7:0]  eRow;
      logic [19:0] eCol;
      @(negedge clk);
      eRow = '0;
      eCol = '0;
      if (expLit()) begin
        eRow[mRow] = 1'b1;
        for (int c = 0; c < 20; c++) eCol[c] = dotLatch[8*c + mRow];
      end
      checks++;
      if (rowEn !== eRow || colEn !== eCol) begin
        errors++;
        $display("FAIL %s row %0d slot %0d: rowEn=%h colEn=%h expected rowEn=%h colEn=%h",
                 tag, mRow, mSlot, rowEn, colEn, eRow, eCol);
      end
    end
  endtask

  task automatic measureRun(output int len);
    do @(negedge clk); while (rowEn != 0);
    do @(negedge clk); while (rowEn == 0);
    len = 0;
    while (rowEn != 0) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic checkVal(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic testReset();  // R11
    rstN = 1'b0;
    intTick = 1'b1;
    repeat (3) @(negedge clk);
    checkVal(int'(rowEn), 0, "R11 rowEn during reset");
    checkVal(int'(colEn), 0, "R11 colEn during reset");
    rstN = 1'b1;
    compareFor(80, "R11 R5 first slots after reset");
  endtask

  task automatic testScan();  // R1 R2 R4 R5
    ctrlWord0 = 7'b1001111;
    compareFor(1100, "R1 R2 R4 R5 full scan");
  endtask

  task automatic testPwmCodes();  // R3
    for (int code = 0; code < 16; code++) begin
      int litCount = 0;
      ctrlWord0 = {3'b100, 4'(code)};
      for (int i = 0; i < 512; i++) begin
        @(negedge clk);
        if (rowEn != 0) litCount++;
      end
      checkVal(litCount, 7 * tbTable(4'(code)), "R3 lit ticks per refresh");
      compareFor(130, "R3 lit window");
    end
  endtask

  task automatic testPatterns();  // R4
    ctrlWord0 = 7'b1001111;
    dotLatch = '1;
    compareFor(512, "R4 all ones");
    dotLatch = {20{8'b1000_0010}};
    compareFor(512, "R4 sparse rows");
    for (int k = 0; k < 160; k++) dotLatch[k] = ((k * 7 + 3) % 5) < 2;
    compareFor(512, "R4 mixed pattern");
  endtask

  task automatic testTickGaps();  // R9 rate
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      intTick = (i % 3) == 0;
    end
    intTick = 1'b1;
    compareFor(300, "R9 R1 sparse internal ticks");
  endtask

  task automatic testBlank();  // R6
    blank = 1'b1;
    compareFor(150, "R6 blank forces dark");
    blank = 1'b0;
    compareFor(300, "R6 counting continued under blank");
  endtask

  task automatic testSleep();  // R7
    ctrlWord0[6] = 1'b0;
    compareFor(200, "R7 sleep dark");
    ctrlWord0[6] = 1'b1;
    compareFor(400, "R7 resume position");
  endtask

  task automatic testPeak();  // R10
    for (int p = 0; p < 4; p++) begin
      ctrlWord0[5:4] = 2'(p);
      @(negedge clk);
      checkVal(int'(peakCode), p, "R10 peak code");
    end
    ctrlWord0[5:4] = 2'b00;
  endtask

  task automatic testExternal();  // R8
    int len;
    ctrlWord0 = 7'b1001111;
    ctrlWord1 = 7'b0;
    useInternal = 1'b0;
    intTick = 1'b1;
    extHalf = 4;
    extRun = 1'b1;
    measureRun(len);
    checkVal(len, 60 * 8, "R8 external run, no prescale");
    ctrlWord1 = 7'b0000010;
    measureRun(len);
    measureRun(len);
    checkVal(len, 60 * 8 * 8, "R8 external run, divide by 8");
    extRun = 1'b0;
  endtask

  task automatic testInternalPrescale();  // R9
    int len;
    useInternal = 1'b1;
    intTick = 1'b1;
    ctrlWord1 = 7'b0000010;
    measureRun(len);
    checkVal(len, 60, "R9 prescale bit ignored for internal tick");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testScan();
    testPwmCodes();
    testPatterns();
    testTickGaps();
    testBlank();
    testSleep();
    testPeak();
    testExternal();
    testInternalPrescale();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule